// File: doc/BRIEF.md
# Per-Pin Timing Waveform Formatter

This block turns one logic value per pin per test vector into a timed waveform inside a test period, and captures each pin's response at a point chosen for that pin. A test period is cut into ten equal slots, numbered 0 to 9. The slots are counted in the fast system clock from a slot tick. A period-start strobe opens each period.

Each pin has a timing record with four fields: a waveform format, a delay slot, a duration in slots and a sample slot. The three formats are non-return-to-zero, return-to-zero and return-to-one. A pattern sequencer presents the vector bits and the timing records, then strobes the start of each period and ticks the slots. The block returns the driven levels and, once per period for each pin, a captured response bit with a one-clock valid strobe. Because the shortest slot is one clock, a period can be no shorter than ten clocks.

Top module: `pin_waveform_formatter`

## Requirements
- R1: A period-start strobe sets the slot count to 0, and it takes precedence over a slot tick in the same cycle. Each later tick advances the count by one. Ticks at slot 9 leave the count, and so every drive level, unchanged. Ticks that come before the first period start are ignored.
- R2: Each pin's record is 14 bits: [13:12] format, [11:8] delay, [7:4] duration, [3:0] sample slot. Delay, duration and sample slot values above 9 are treated as 9. The vector bit and the record are taken at the period start, so changes to them during the period have no effect until the next period start.
- R3: Format 00 (NRZ): from the delay slot to the end of the period the pin drives the vector bit. Before the delay slot it keeps the level it drove in the last slot of the previous period.
- R4: Format 01 (RZ): the pin drives the vector bit during the window of slots from delay to delay+duration-1, and drives 0 in every other slot.
- R5: Format 10 (RO): the pin drives the vector bit inside the same window, and drives 1 in every other slot.
- R6: A window that runs past slot 9 ends at the end of the period. A duration of 0 gives an empty window.
- R7: Format 11 behaves as NRZ.
- R8: In the clock after the first clock of a pin's sample slot, sample_valid_o of that pin is high for one clock. sample_o then holds the pin response as it was at that clock edge. This happens once per period, and repeated ticks at slot 9 never produce a second capture.
- R9: After reset, and until the first period start, every drive level is 0, and every sample and valid bit is 0. The NRZ level carried over into the first period is 0.
- R10: A drive level changes only in the clock after a period start or an accepted slot tick, and it reflects the new slot from that clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_tick_i | input | 1 | Advance to the next slot |
| period_start_i | input | 1 | Begin a new period at slot 0 |
| vec_bit_i | input | NUM_PINS | Vector value for each pin |
| timing_i | input | NUM_PINS x 14 | Timing record for each pin |
| pin_resp_i | input | NUM_PINS | Response level of each pin |
| drive_o | output | NUM_PINS | Driven waveform level of each pin |
| sample_o | output | NUM_PINS | Captured response of each pin |
| sample_valid_o | output | NUM_PINS | One-clock strobe for each new capture |

## Verification
Two events can fall in the same cycle: a period start and a slot tick. The bench raises both strobes in the opening cycle of one period. It then checks that every pin shows its slot-0 waveform and that later captures land on the programmed slots, as if the tick had been absent. A second collision happens when a new period opens while NRZ pins are still carrying the previous period's level. This is judged by comparing every slot before the delay against the level the bench model predicts for the last slot of the period before.

// File: rtl/pinfmt_pkg.sv
package pinfmt_pkg;
  localparam int NUM_SLOTS = 10;
  localparam int SLOT_W    = 4;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  typedef enum logic [1:0] {
    FMT_NRZ = 2'b00,
    FMT_RZ  = 2'b01,
    FMT_RO  = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

  typedef struct packed {
    fmt_e              fmt;
    logic [SLOT_W-1:0] delay;
    logic [SLOT_W-1:0] dur;
    logic [SLOT_W-1:0] samp;
  } timing_rec_t;

  localparam int REC_W = $bits(timing_rec_t);

  function automatic logic [SLOT_W-1:0] clamp_slot(input logic [SLOT_W-1:0] v);
    return (v > LAST_SLOT) ? LAST_SLOT : v;
  endfunction
endpackage

// File: rtl/pinfmt_slot_timer.sv
module pinfmt_slot_timer
  import pinfmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_tick_i,
  input  logic              period_start_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              slot_new_o,
  output logic              started_o
);
  logic [SLOT_W-1:0] slot_q;
  logic              new_q, started_q;
  logic              advance;

  assign advance = slot_tick_i && started_q && (slot_q != LAST_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q    <= '0;
      new_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      new_q <= 1'b0;
      if (period_start_i) begin
        slot_q    <= '0;
        new_q     <= 1'b1;
        started_q <= 1'b1;
      end else if (advance) begin
        slot_q <= slot_q + 1'b1;
        new_q  <= 1'b1;
      end
    end
  end

  assign slot_o     = slot_q;
  assign slot_new_o = new_q;
  assign started_o  = started_q;

  assert_slot_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= LAST_SLOT);
  assert_start_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_i |=> (slot_o == '0) && slot_new_o);
  assert_tick_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_tick_i && !period_start_i && started_o && slot_o != LAST_SLOT)
      |=> slot_o == $past(slot_o) + 1'b1);
  assert_saturate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!period_start_i && slot_o == LAST_SLOT) |=> (slot_o == LAST_SLOT) && !slot_new_o);
endmodule

// File: rtl/pinfmt_pin_formatter.sv
module pinfmt_pin_formatter
  import pinfmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              period_start_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              started_i,
  input  logic              vec_bit_i,
  input  timing_rec_t       rec_i,
  output logic              drive_o,
  output logic [SLOT_W-1:0] samp_slot_o
);
  fmt_e              fmt_q;
  logic [SLOT_W-1:0] dly_q, dur_q, samp_q;
  logic              vec_q, held_q;
  logic [SLOT_W:0]   win_end;
  logic              in_win, past_dly;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= FMT_NRZ;
      dly_q  <= '0;
      dur_q  <= '0;
      samp_q <= '0;
      vec_q  <= 1'b0;
      held_q <= 1'b0;
    end else if (period_start_i) begin
      fmt_q  <= rec_i.fmt;
      dly_q  <= clamp_slot(rec_i.delay);
      dur_q  <= clamp_slot(rec_i.dur);
      samp_q <= clamp_slot(rec_i.samp);
      vec_q  <= vec_bit_i;
      held_q <= drive_o;  // level carried into the next NRZ prefix
    end
  end

  // window stops at the period end since slot never exceeds LAST_SLOT
  assign win_end  = {1'b0, dly_q} + {1'b0, dur_q};
  assign past_dly = (slot_i >= dly_q);
  assign in_win   = past_dly && ({1'b0, slot_i} < win_end);

  always_comb begin
    if (!started_i) begin
      drive_o = 1'b0;
    end else begin
      unique case (fmt_q)
        FMT_RZ:  drive_o = in_win ? vec_q : 1'b0;
        FMT_RO:  drive_o = in_win ? vec_q : 1'b1;
        default: drive_o = past_dly ? vec_q : held_q;
      endcase
    end
  end

  assign samp_slot_o = samp_q;

  assert_rec_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_i |=> (fmt_q == $past(rec_i.fmt)) && (vec_q == $past(vec_bit_i)));
  assert_rz_idle_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_i && fmt_q == FMT_RZ && slot_i < dly_q) |-> !drive_o);
  assert_ro_idle_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_i && fmt_q == FMT_RO && slot_i < dly_q) |-> drive_o);
  assert_no_drive_before_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_i |-> !drive_o);
endmodule

// File: rtl/pinfmt_pin_sampler.sv
module pinfmt_pin_sampler
  import pinfmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              slot_new_i,
  input  logic [SLOT_W-1:0] samp_slot_i,
  input  logic              pin_resp_i,
  output logic              sample_o,
  output logic              valid_o
);
  logic hit;

  assign hit = slot_new_i && (slot_i == samp_slot_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= hit;
      if (hit) sample_o <= pin_resp_i;
    end
  end

  assert_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> valid_o && (sample_o == $past(pin_resp_i)));
  assert_no_spurious_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_new_i |=> !valid_o);
endmodule

// File: rtl/pin_waveform_formatter.sv
module pin_waveform_formatter
  import pinfmt_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           slot_tick_i,
  input  logic                           period_start_i,
  input  logic [NUM_PINS-1:0]            vec_bit_i,
  input  logic [NUM_PINS-1:0][REC_W-1:0] timing_i,
  input  logic [NUM_PINS-1:0]            pin_resp_i,
  output logic [NUM_PINS-1:0]            drive_o,
  output logic [NUM_PINS-1:0]            sample_o,
  output logic [NUM_PINS-1:0]            sample_valid_o
);
  logic [SLOT_W-1:0] slot;
  logic              slot_new, started;

  pinfmt_slot_timer u_timer (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .slot_tick_i    (slot_tick_i),
    .period_start_i (period_start_i),
    .slot_o         (slot),
    .slot_new_o     (slot_new),
    .started_o      (started)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [SLOT_W-1:0] samp_slot;

    pinfmt_pin_formatter u_fmt (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .period_start_i (period_start_i),
      .slot_i         (slot),
      .started_i      (started),
      .vec_bit_i      (vec_bit_i[g]),
      .rec_i          (timing_rec_t'(timing_i[g])),
      .drive_o        (drive_o[g]),
      .samp_slot_o    (samp_slot)
    );

    pinfmt_pin_sampler u_smp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .slot_i      (slot),
      .slot_new_i  (slot_new),
      .samp_slot_i (samp_slot),
      .pin_resp_i  (pin_resp_i[g]),
      .sample_o    (sample_o[g]),
      .valid_o     (sample_valid_o[g])
    );
  end

  assert_drive_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!period_start_i && !slot_tick_i) |=> $stable(drive_o));
endmodule

// File: tb/pin_waveform_formatter_tb.sv
module pin_waveform_formatter_tb;
  localparam int NP = 4;
  localparam int RW = 14;

  // entry: {vec[3:0], rec3, rec2, rec1, rec0}; rec = {fmt, delay, dur, samp}
  localparam logic [NP*RW+NP-1:0] TBL [4] = '{
    {4'b1011, {2'b00,4'd5,4'd0,4'd2},  {2'b10,4'd4,4'd3,4'd9},
              {2'b01,4'd3,4'd5,4'd5},  {2'b00,4'd0,4'd0,4'd0}},
    {4'b0101, {2'b00,4'd5,4'd0,4'd7},  {2'b00,4'd3,4'd0,4'd3},
              {2'b10,4'd12,4'd2,4'd0}, {2'b01,4'd7,4'd5,4'd15}},
    {4'b0111, {2'b10,4'd9,4'd9,4'd6},  {2'b01,4'd0,4'd15,4'd8},
              {2'b11,4'd2,4'd0,4'd1},  {2'b01,4'd0,4'd0,4'd4}},
    {4'b0101, {2'b10,4'd0,4'd9,4'd9},  {2'b00,4'd0,4'd0,4'd0},
              {2'b00,4'd9,4'd0,4'd15}, {2'b00,4'd9,4'd0,4'd9}}
  };

  logic                    clk = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    slot_tick_i = 1'b0;
  logic                    period_start_i = 1'b0;
  logic [NP-1:0]           vec_bit_i = '0;
  logic [NP-1:0][RW-1:0]   timing_i = '0;
  logic [NP-1:0]           pin_resp_i = '0;
  logic [NP-1:0]           drive_o, sample_o, sample_valid_o;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  held [NP];

  always #10ns clk = ~clk;

  pin_waveform_formatter #(.NUM_PINS(NP)) u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .slot_tick_i    (slot_tick_i),
    .period_start_i (period_start_i),
    .vec_bit_i      (vec_bit_i),
    .timing_i       (timing_i),
    .pin_resp_i     (pin_resp_i),
    .drive_o        (drive_o),
    .sample_o       (sample_o),
    .sample_valid_o (sample_valid_o)
  );

  function automatic int clampv(input logic [3:0] v);
    return (v > 4'd9) ? 9 : int'(v);
  endfunction

  function automatic bit exp_drive(input logic [RW-1:0] rec, input int s,
                                   input bit v, input bit h);
    int  d  = clampv(rec[11:8]);
    int  du = clampv(rec[7:4]);
    bit  inw = (s >= d) && (s < d + du);
    case (rec[13:12])
      2'b01:   return inw ? v : 1'b0;
      2'b10:   return inw ? v : 1'b1;
      default: return (s >= d) ? v : h;
    endcase
  endfunction

  function automatic logic [NP-1:0] resp_pat(input int s);
    return NP'((s * 7 + 5) % 16);
  endfunction

  task automatic check(input bit act, input bit exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // one full period; entered and left at a falling edge
  task automatic run_period(input logic [NP*RW+NP-1:0] ent, input bit collide);
    logic [NP-1:0] vec;
    vec = ent[NP*RW +: NP];
    for (int s = 0; s < 10; s++) begin
      period_start_i = (s == 0);
      slot_tick_i    = (s != 0) || collide;
      if (s == 0) begin
        for (int p = 0; p < NP; p++) timing_i[p] = ent[p*RW +: RW];
        vec_bit_i = vec;
      end
      @(posedge clk); @(negedge clk);
      period_start_i = 1'b0;
      slot_tick_i    = 1'b0;
      if (s == 0) begin
        // scrambled mid-period record and vector must be ignored (R2)
        for (int p = 0; p < NP; p++) timing_i[p] = ~ent[p*RW +: RW];
        vec_bit_i = ~vec;
      end
      pin_resp_i = resp_pat(s);
      for (int p = 0; p < NP; p++)
        check(drive_o[p], exp_drive(ent[p*RW +: RW], s, vec[p], held[p]),
              "R3/R4/R5/R6/R7 with R2 and R10",
              $sformatf("drive pin %0d slot %0d", p, s));
      @(posedge clk); @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        bit ev = (s == clampv(ent[p*RW +: 4]));
        check(sample_valid_o[p], ev, "R8", $sformatf("valid pin %0d slot %0d", p, s));
        if (ev)
          check(sample_o[p], resp_pat(s)[p], "R8", $sformatf("sample pin %0d slot %0d", p, s));
      end
    end
    for (int p = 0; p < NP; p++)
      held[p] = exp_drive(ent[p*RW +: RW], 9, vec[p], held[p]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) held[p] = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    for (int p = 0; p < NP; p++) begin
      check(drive_o[p], 1'b0, "R9", $sformatf("reset drive pin %0d", p));
      check(sample_valid_o[p], 1'b0, "R9", $sformatf("reset valid pin %0d", p));
      check(sample_o[p], 1'b0, "R9", $sformatf("reset sample pin %0d", p));
    end
    rst_ni = 1'b1;
    @(negedge clk);
    // R1/R9: ticks before the first period start do nothing
    vec_bit_i = '1;
    for (int p = 0; p < NP; p++) timing_i[p] = {2'b10, 4'd0, 4'd0, 4'd0};
    for (int k = 0; k < 3; k++) begin
      slot_tick_i = 1'b1;
      @(posedge clk); @(negedge clk);
      slot_tick_i = 1'b0;
      @(posedge clk); @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        check(drive_o[p], 1'b0, "R1", $sformatf("pre-start tick drive pin %0d", p));
        check(sample_valid_o[p], 1'b0, "R1", $sformatf("pre-start tick valid pin %0d", p));
      end
    end

    // table walk; entry 2 opens with start and tick together (R1)
    for (int e = 0; e < 4; e++) run_period(TBL[e], e == 2);

    // R1/R8: extra ticks at slot 9 change nothing and capture nothing
    for (int k = 0; k < 3; k++) begin
      slot_tick_i = 1'b1;
      @(posedge clk); @(negedge clk);
      slot_tick_i = 1'b0;
      for (int p = 0; p < NP; p++)
        check(drive_o[p], held[p], "R1", $sformatf("saturated drive pin %0d", p));
      @(posedge clk); @(negedge clk);
      for (int p = 0; p < NP; p++)
        check(sample_valid_o[p], 1'b0, "R8", $sformatf("saturated valid pin %0d", p));
    end
    finish_run();
  end
endmodule